// File: doc/BRIEF.md
# Serial Configuration Register File

This block accepts 24-bit control words over a three-wire serial link (serial clock, serial data, strobe) and keeps them in four configuration registers. The two leading bits of each word pick the destination register. Of the four, two hold alternative operating sets, for example one for transmit and one for receive. A live mode input chooses which of the two drives the frequency-divider, attenuation and transmit/receive outputs, so the device can switch sets without any serial traffic. The other two registers hold the clock-divider settings and the trim settings.

All three serial lines are brought into the system clock domain through two-flop synchronizers. Edges are then detected on the synchronized copies. Bits shift in most significant first on each serial-clock rise. A strobe rise that arrives while the serial clock is low copies the last 24 shifted bits into the addressed register.

An active-low standby input gates a power-enable output through its own synchronizer. The registers stay writable while the device is in standby. Reserved attenuation and charge-pump codes are stored unchanged and reported on flag outputs.

Top module: `serial_cfg_regfile`

## Requirements
- R1: A word is 24 bits, shifted most significant bit first, one bit on each rise of the serial clock. Bits 23:22 address the destination: 00 is mode set 0, 01 is mode set 1, 10 is the divider word, 11 is the trim word. Bits 21:0 are the stored payload.
- R2: A strobe rise with the serial clock low commits the word. A strobe rise with the serial clock high stores nothing. The outputs show a committed word from the third system clock edge after the strobe rise reaches the input.
- R3: After reset, every payload bit is 0 except these: bits 7:6 of both mode words reset to 10, and bit 15 of the trim word resets to 1.
- R4: With mode_sel_i low, the active fields come from mode word 0. With mode_sel_i high, they come from mode word 1. The active fields are A coefficient = bits 21:17, B coefficient = bits 16:8, attenuation = bits 7:6 (00 = 10 dB, 01 = 20 dB, 10 = 0 dB) and transmit select = bit 5. The mode input acts combinationally.
- R5: Mode word 0 alone supplies the charge-pump current, bits 3:2 (00 = 0.5 mA, 01 = 1 mA, 10 = 0.25 mA), and the converter enable, bit 0.
- R6: Mode word 1 alone supplies the following fields: bit 4 is the modulation select (1 = FSK, 0 = OOK), bit 3 is the clock-buffer enable, bits 2:1 are the brownout threshold, and bit 0 is the brownout enable.
- R7: The divider word supplies the reference divider (bits 21:14), the buffer clock divider (bits 12:8) and the converter clock divider (bits 6:0).
- R8: The trim word supplies the crystal trim (bits 18:16), the phase-detector reset (bit 15) and the demodulator tune (bits 14:12).
- R9: Code 11 in the active attenuation field is presented unchanged and raises atten_bad_o. Code 11 in the charge-pump field is presented unchanged and raises cp_bad_o.
- R10: When more than 24 bits arrive before a strobe, only the last 24 bits shifted in are committed.
- R11: pwr_en_o follows standby_n_i two system clock edges later and is low in reset. Words written while in standby are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk_i | input | 1 | Serial clock |
| ser_dat_i | input | 1 | Serial data |
| ser_stb_i | input | 1 | Serial strobe |
| mode_sel_i | input | 1 | Chooses mode set 0 (low) or 1 (high) |
| standby_n_i | input | 1 | Active-low standby |
| a_coef_o | output | 5 | Active A divider coefficient |
| b_coef_o | output | 9 | Active B divider coefficient |
| pa_atten_o | output | 2 | Active attenuation code |
| tx_sel_o | output | 1 | Active transmit/receive select |
| cp_curr_o | output | 2 | Charge-pump current code |
| dcdc_en_o | output | 1 | Converter enable |
| fsk_sel_o | output | 1 | 1 = FSK, 0 = OOK |
| clkbuf_en_o | output | 1 | Clock-buffer enable |
| bo_thresh_o | output | 2 | Brownout threshold select |
| bo_en_o | output | 1 | Brownout enable |
| ref_div_o | output | 8 | Reference divider |
| clk_div_o | output | 5 | Buffer clock divider |
| sw_div_o | output | 7 | Converter clock divider |
| xtal_trim_o | output | 3 | Crystal trim |
| pfd_rst_o | output | 1 | Phase-detector reset |
| dem_tune_o | output | 3 | Demodulator tune |
| pwr_en_o | output | 1 | Power enable for the other blocks |
| atten_bad_o | output | 1 | Active attenuation code is 11 |
| cp_bad_o | output | 1 | Charge-pump code is 11 |

## Verification
The checker enforces the following on every cycle:
- at most one register write is enabled at a time;
- a commit lands the shifted payload in the addressed register;
- the register bank holds still whenever no commit occurs;
- a mode flip between differing sets moves the active outputs;
- pwr_en_o changes only as standby_n_i did two edges earlier.

Some behaviours can only be shown by the bench's scenarios:
- the reset contents;
- the bit order and address decode over the serial link;
- rejection of a strobe raised while the serial clock is high;
- the last-24-bits rule on overlong words;
- the flags for the reserved codes.

The bench's cycle-accurate model compares every output on every clock.

// File: rtl/scfg_pkg.sv
`timescale 1ns/1ps
package scfg_pkg;
  localparam int WORD_W    = 24;
  localparam int ADDR_W    = 2;
  localparam int PAY_W     = WORD_W - ADDR_W;
  localparam int NUM_WORDS = 1 << ADDR_W;
  // span of a mode word that the mode input switches
  localparam int SEL_HI    = 21;
  localparam int SEL_LO    = 5;
  localparam int SEL_W     = SEL_HI - SEL_LO + 1;

  typedef enum logic [ADDR_W-1:0] {
    W_MODE0 = 2'b00,
    W_MODE1 = 2'b01,
    W_DIV   = 2'b10,
    W_TRIM  = 2'b11
  } word_sel_e;

  localparam logic [PAY_W-1:0] MODE_RST = PAY_W'(22'h000080); // attenuation = 10
  localparam logic [PAY_W-1:0] TRIM_RST = PAY_W'(22'h008000); // phase-detector reset = 1

  function automatic logic [PAY_W-1:0] rst_value(input int idx);
    case (idx)
      int'(W_MODE0), int'(W_MODE1): rst_value = MODE_RST;
      int'(W_TRIM):                 rst_value = TRIM_RST;
      default:                      rst_value = '0;
    endcase
  endfunction
endpackage

// File: rtl/scfg_sync.sv
`timescale 1ns/1ps
module scfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q, st_d;

  always_comb begin
    st_d = {st_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/scfg_shifter.sv
`timescale 1ns/1ps
module scfg_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              sstb_s,
  output logic              wr_en,
  output logic [WORD_W-1:0] word
);
  logic              sclk_q, sstb_q;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              clk_rise, stb_rise;

  assign clk_rise = sclk_s & ~sclk_q;
  assign stb_rise = sstb_s & ~sstb_q;

  // shift only on a serial-clock rise; older bits fall off the top
  always_comb begin
    sh_d = sh_q;
    if (clk_rise) sh_d = {sh_q[WORD_W-2:0], sdat_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sstb_q <= 1'b0;
      sh_q   <= '0;
    end else begin
      sclk_q <= sclk_s;
      sstb_q <= sstb_s;
      sh_q   <= sh_d;
    end
  end

  // commit only while the serial clock rests low
  assign wr_en = stb_rise & ~sclk_s;
  assign word  = sh_q;
endmodule

// File: rtl/scfg_bank.sv
`timescale 1ns/1ps
module scfg_bank
  import scfg_pkg::*;
#(
  parameter  int NUM = NUM_WORDS,
  parameter  int PW  = PAY_W,
  localparam int AW  = $clog2(NUM)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [PW-1:0]           wr_data,
  output logic [NUM-1:0][PW-1:0]  words,
  output logic [NUM-1:0]          wen
);
  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic [PW-1:0] r_q, r_d;
    assign wen[g] = wr_en && (wr_addr == AW'(g));
    always_comb begin
      r_d = r_q;
      if (wen[g]) r_d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= PW'(rst_value(g));
      else        r_q <= r_d;
    end
    assign words[g] = r_q;
  end
endmodule

// File: rtl/serial_cfg_regfile.sv
`timescale 1ns/1ps
module serial_cfg_regfile
  import scfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk_i,
  input  logic       ser_dat_i,
  input  logic       ser_stb_i,
  input  logic       mode_sel_i,
  input  logic       standby_n_i,
  output logic [4:0] a_coef_o,
  output logic [8:0] b_coef_o,
  output logic [1:0] pa_atten_o,
  output logic       tx_sel_o,
  output logic [1:0] cp_curr_o,
  output logic       dcdc_en_o,
  output logic       fsk_sel_o,
  output logic       clkbuf_en_o,
  output logic [1:0] bo_thresh_o,
  output logic       bo_en_o,
  output logic [7:0] ref_div_o,
  output logic [4:0] clk_div_o,
  output logic [6:0] sw_div_o,
  output logic [2:0] xtal_trim_o,
  output logic       pfd_rst_o,
  output logic [2:0] dem_tune_o,
  output logic       pwr_en_o,
  output logic       atten_bad_o,
  output logic       cp_bad_o
);
  logic                             rst_n_int;
  logic [2:0]                       ser_s;
  logic                             wr_en;
  logic [WORD_W-1:0]                word;
  logic [ADDR_W-1:0]                wr_addr;
  logic [PAY_W-1:0]                 wr_data;
  logic [NUM_WORDS-1:0][PAY_W-1:0]  words;
  logic [NUM_WORDS-1:0]             wen;
  logic [SEL_W-1:0]                 act_sel;
  logic [PAY_W-1:0]                 w_m0, w_m1, w_div, w_trim;

  scfg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_int));

  scfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_ser_sync (
    .clk(clk), .rst_n(rst_n_int),
    .d({ser_clk_i, ser_dat_i, ser_stb_i}), .q(ser_s));

  scfg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sby_sync (
    .clk(clk), .rst_n(rst_n_int), .d(standby_n_i), .q(pwr_en_o));

  scfg_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n_int),
    .sclk_s(ser_s[2]), .sdat_s(ser_s[1]), .sstb_s(ser_s[0]),
    .wr_en(wr_en), .word(word));

  assign wr_addr = word[WORD_W-1 -: ADDR_W];
  assign wr_data = word[PAY_W-1:0];

  scfg_bank #(.NUM(NUM_WORDS), .PW(PAY_W)) u_bank (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .words(words), .wen(wen));

  assign w_m0   = words[W_MODE0];
  assign w_m1   = words[W_MODE1];
  assign w_div  = words[W_DIV];
  assign w_trim = words[W_TRIM];

  // live choice between the two shadowed mode sets
  assign act_sel = mode_sel_i ? w_m1[SEL_HI:SEL_LO] : w_m0[SEL_HI:SEL_LO];

  assign a_coef_o    = act_sel[16:12];
  assign b_coef_o    = act_sel[11:3];
  assign pa_atten_o  = act_sel[2:1];
  assign tx_sel_o    = act_sel[0];
  assign atten_bad_o = &act_sel[2:1];

  assign cp_curr_o   = w_m0[3:2];
  assign cp_bad_o    = &w_m0[3:2];
  assign dcdc_en_o   = w_m0[0];

  assign fsk_sel_o   = w_m1[4];
  assign clkbuf_en_o = w_m1[3];
  assign bo_thresh_o = w_m1[2:1];
  assign bo_en_o     = w_m1[0];

  assign ref_div_o   = w_div[21:14];
  assign clk_div_o   = w_div[12:8];
  assign sw_div_o    = w_div[6:0];

  assign xtal_trim_o = w_trim[18:16];
  assign pfd_rst_o   = w_trim[15];
  assign dem_tune_o  = w_trim[14:12];

  logic unused_bits;
  assign unused_bits = ^{w_m0[4], w_m0[1], w_div[13], w_div[7],
                         w_trim[21:19], w_trim[11:0]};
endmodule

// File: rtl/serial_cfg_regfile_chk.sv
`timescale 1ns/1ps
module serial_cfg_regfile_chk
  import scfg_pkg::*;
(
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic [ADDR_W-1:0]               wr_addr,
  input logic [PAY_W-1:0]                wr_data,
  input logic [NUM_WORDS-1:0][PAY_W-1:0] words,
  input logic [NUM_WORDS-1:0]            wen,
  input logic                            mode_sel_i,
  input logic [SEL_W-1:0]                act_out,
  input logic                            standby_n_i,
  input logic                            pwr_en_o
);
  assert_single_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wen));

  assert_commit_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> words[$past(wr_addr)] == $past(wr_data));

  assert_hold_without_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(words));

  assert_mode_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mode_sel_i) && $stable(words) &&
     (words[W_MODE0][SEL_HI:SEL_LO] != words[W_MODE1][SEL_HI:SEL_LO]))
    |-> !$stable(act_out));

  assert_wake_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en_o) |-> $past(standby_n_i, 2));

  assert_sleep_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en_o) |-> !$past(standby_n_i, 2));
endmodule

bind serial_cfg_regfile serial_cfg_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .words(words), .wen(wen), .mode_sel_i(mode_sel_i),
  .act_out({a_coef_o, b_coef_o, pa_atten_o, tx_sel_o}),
  .standby_n_i(standby_n_i), .pwr_en_o(pwr_en_o));

// File: tb/serial_cfg_regfile_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_regfile_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b0;
  logic mode_sel = 1'b0, standby_n = 1'b0;
  logic [4:0] a_coef; logic [8:0] b_coef; logic [1:0] pa_atten; logic tx_sel;
  logic [1:0] cp_curr; logic dcdc_en, fsk_sel, clkbuf_en; logic [1:0] bo_thresh;
  logic bo_en; logic [7:0] ref_div; logic [4:0] clk_div; logic [6:0] sw_div;
  logic [2:0] xtal_trim; logic pfd_rst; logic [2:0] dem_tune;
  logic pwr_en, atten_bad, cp_bad;

  serial_cfg_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_stb_i(ser_stb), .mode_sel_i(mode_sel), .standby_n_i(standby_n),
    .a_coef_o(a_coef), .b_coef_o(b_coef), .pa_atten_o(pa_atten), .tx_sel_o(tx_sel),
    .cp_curr_o(cp_curr), .dcdc_en_o(dcdc_en), .fsk_sel_o(fsk_sel),
    .clkbuf_en_o(clkbuf_en), .bo_thresh_o(bo_thresh), .bo_en_o(bo_en),
    .ref_div_o(ref_div), .clk_div_o(clk_div), .sw_div_o(sw_div),
    .xtal_trim_o(xtal_trim), .pfd_rst_o(pfd_rst), .dem_tune_o(dem_tune),
    .pwr_en_o(pwr_en), .atten_bad_o(atten_bad), .cp_bad_o(cp_bad));

  int checks = 0, failures = 0, cyc = 0;
  bit cmp_on = 0;

  // reference model state
  logic [21:0] exp_w [4];
  bit sbits[$];
  typedef struct { int due; logic [23:0] w; } pend_t;
  pend_t pq[$];
  logic sb1 = 0, sb2 = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    exp_w[0] = 22'h000080; exp_w[1] = 22'h000080;   // R3
    exp_w[2] = 22'h0;      exp_w[3] = 22'h008000;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin sb1 = 0; sb2 = 0; model_reset(); end
    else begin sb2 = sb1; sb1 = standby_n; end
    while (pq.size() > 0 && pq[0].due == cyc) begin
      exp_w[pq[0].w[23:22]] = pq[0].w[21:0];
      void'(pq.pop_front());
    end
    #1;
    if (cmp_on) begin
      logic [21:0] s;
      s = mode_sel ? exp_w[1] : exp_w[0];
      chk("R4 a_coef", a_coef, s[21:17]);
      chk("R4 b_coef", b_coef, s[16:8]);
      chk("R4 atten", pa_atten, s[7:6]);
      chk("R4 tx_sel", tx_sel, s[5]);
      chk("R5 cp_curr", cp_curr, exp_w[0][3:2]);
      chk("R5 dcdc", dcdc_en, exp_w[0][0]);
      chk("R6 fsk", fsk_sel, exp_w[1][4]);
      chk("R6 clkbuf", clkbuf_en, exp_w[1][3]);
      chk("R6 bo_thresh", bo_thresh, exp_w[1][2:1]);
      chk("R6 bo_en", bo_en, exp_w[1][0]);
      chk("R7 ref_div", ref_div, exp_w[2][21:14]);
      chk("R7 clk_div", clk_div, exp_w[2][12:8]);
      chk("R7 sw_div", sw_div, exp_w[2][6:0]);
      chk("R8 xtal", xtal_trim, exp_w[3][18:16]);
      chk("R8 pfd", pfd_rst, exp_w[3][15]);
      chk("R8 dem", dem_tune, exp_w[3][14:12]);
      chk("R9 atten_bad", atten_bad, s[7:6] == 2'b11);
      chk("R9 cp_bad", cp_bad, exp_w[0][3:2] == 2'b11);
      chk("R11 pwr_en", pwr_en, sb2);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [63:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      wait_cyc(3);
      ser_clk = 1'b1; sbits.push_back(bits[i]);
      wait_cyc(3);
      ser_clk = 1'b0;
      wait_cyc(3);
    end
  endtask

  function automatic logic [23:0] last24();
    logic [23:0] w = '0;
    int st = (sbits.size() > 24) ? sbits.size() - 24 : 0;
    for (int k = st; k < sbits.size(); k++) w = {w[22:0], sbits[k]};
    return w;
  endfunction

  task automatic strobe();
    pend_t p;
    ser_stb = 1'b1;
    if (ser_clk == 1'b0) begin p.due = cyc + 3; p.w = last24(); pq.push_back(p); end
    wait_cyc(4);
    ser_stb = 1'b0;
    wait_cyc(4);
  endtask

  task automatic send_word(input logic [1:0] a, input logic [21:0] d);
    shift_bits({40'h0, a, d}, 24);
    strobe();
    wait_cyc(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    wait_cyc(5);
    cmp_on = 1;
    rst_n = 1'b1;
    wait_cyc(6);
    // R3 reset contents
    chk("R3 atten reset", pa_atten, 2'b10);
    chk("R3 pfd reset", pfd_rst, 1'b1);
    chk("R3 a_coef reset", a_coef, 0);
    chk("R3 ref_div reset", ref_div, 0);
    chk("R11 pwr_en in standby", pwr_en, 0);
    standby_n = 1'b1;
    wait_cyc(4);
    chk("R11 pwr_en awake", pwr_en, 1);

    // R1: mode word 0
    send_word(2'b00, {5'h13, 9'h0A5, 2'b01, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1});
    chk("R1 a_coef mode0", a_coef, 5'h13);
    chk("R1 b_coef mode0", b_coef, 9'h0A5);
    chk("R5 cp_curr", cp_curr, 2'b01);
    chk("R5 dcdc", dcdc_en, 1);
    // mode word 1
    send_word(2'b01, {5'h0C, 9'h1F0, 2'b00, 1'b0, 1'b1, 1'b1, 2'b10, 1'b1});
    chk("R4 still mode0", a_coef, 5'h13);
    chk("R6 fsk", fsk_sel, 1);
    chk("R6 bo_thresh", bo_thresh, 2'b10);
    mode_sel = 1'b1;
    wait_cyc(2);
    chk("R4 a_coef mode1", a_coef, 5'h0C);
    chk("R4 b_coef mode1", b_coef, 9'h1F0);
    chk("R4 atten mode1", pa_atten, 2'b00);
    chk("R4 tx_sel mode1", tx_sel, 0);
    mode_sel = 1'b0;
    wait_cyc(2);
    chk("R4 back to mode0", tx_sel, 1);

    // R7 and R8
    send_word(2'b10, {8'hC7, 1'b0, 5'h10, 1'b0, 7'h20});
    chk("R7 ref_div", ref_div, 8'hC7);
    chk("R7 clk_div", clk_div, 5'h10);
    chk("R7 sw_div", sw_div, 7'h20);
    send_word(2'b11, {3'b000, 3'b101, 1'b0, 3'b110, 12'h0});
    chk("R8 xtal", xtal_trim, 3'b101);
    chk("R8 pfd", pfd_rst, 0);
    chk("R8 dem", dem_tune, 3'b110);

    // R2: strobe while serial clock high stores nothing
    shift_bits({40'h0, 2'b10, 22'h3FFFFF}, 23);
    ser_dat = 1'b1; wait_cyc(3);
    ser_clk = 1'b1; sbits.push_back(1'b1);
    wait_cyc(4);
    strobe();
    ser_clk = 1'b0;
    wait_cyc(6);
    chk("R2 ignored strobe ref_div", ref_div, 8'hC7);
    chk("R2 ignored strobe sw_div", sw_div, 7'h20);

    // R10 with R9: six leading junk bits then a mode-0 word with 11 codes
    shift_bits({34'h0, 6'b101101, 2'b00, 5'h07, 9'h033, 2'b11, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0}, 30);
    strobe();
    wait_cyc(4);
    chk("R10 a_coef after overlong", a_coef, 5'h07);
    chk("R10 b_coef after overlong", b_coef, 9'h033);
    chk("R9 atten passes 11", pa_atten, 2'b11);
    chk("R9 atten_bad", atten_bad, 1);
    chk("R9 cp_bad", cp_bad, 1);
    mode_sel = 1'b1;
    wait_cyc(2);
    chk("R9 atten_bad clear in mode1", atten_bad, 0);
    mode_sel = 1'b0;

    // R11: standby still allows writes
    standby_n = 1'b0;
    wait_cyc(4);
    chk("R11 pwr_en off", pwr_en, 0);
    send_word(2'b10, {8'h3A, 1'b0, 5'h04, 1'b0, 7'h11});
    chk("R11 write in standby", ref_div, 8'h3A);
    standby_n = 1'b1;
    wait_cyc(4);
    chk("R11 pwr_en on", pwr_en, 1);

    wait_cyc(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule